// File: doc/BRIEF.md
# Main-Clock Failure Guard

The block watches a main clock from a free-running reference clock and holds the chip in reset when the main clock slows down too far or stops. Each rising edge of the main clock flips a toggle flop. A synchronizer carries that toggle into the reference domain, and an edge detector turns each change into a pulse. An idle counter measures the reference cycles since the last pulse. When it reaches a limit equal to 50 µs of reference time (one period of a 20 kHz clock), the guard enters its failure state and asserts its reset output. The guard also runs its own state machine on the reference clock.

Software controls the guard through a two-bit control field. Bit 4 is the enable, which software can write. Bit 5 is a sticky failure flag. Software can clear the flag but never set it. Four reset sources act on these two bits in different ways. A power-on reset clears both bits. A power-fail reset clears only the enable. Any other system reset leaves both bits unchanged and restarts only the monitoring. While software has put the chip into stop mode on purpose, detection is suppressed. Once reset is active, it is released only after main-clock edges have come back and stayed present for a programmable number of reference cycles.

Top module: `clkfail_guard`

## Requirements
- R1: After power-on reset (`porN` low), `failRst` is 0 and `ctrlRdata[5:4]` reads 2'b00.
- R2: A write (`ctrlWe` high) loads the enable from `ctrlWdata[4]`. The enable reads back on `ctrlRdata[4]`.
- R3: With the enable set and `stopMode` low, a gap of at least TIMEOUT = REF_HZ/20000 reference cycles with no detected main-clock edge asserts `failRst`. Gaps shorter than TIMEOUT never assert it.
- R4: While the enable is 0, `failRst` never rises, whatever the main clock does.
- R5: Once asserted, `failRst` stays high until main-clock edges have come back and no timeout has occurred for `recoverLen` consecutive reference cycles.
- R6: The failure flag `ctrlRdata[5]` is set on the same reference edge at which `failRst` rises, and at no other time.
- R7: A write with `ctrlWdata[5]` = 0 clears the flag. A write with `ctrlWdata[5]` = 1 does not set it.
- R8: A `pfRst` pulse clears the enable, leaves the flag unchanged, and ends any active failure.
- R9: A `sysRst` pulse leaves both control bits unchanged, drops `failRst`, and restarts monitoring, so a main clock that is still dead fails again.
- R10: `porN` low clears both the enable and the flag.
- R11: While `stopMode` is high, no failure is raised. When stop mode ends, a full TIMEOUT window starts again from that point.
- R12: Once the main clock stops, `failRst` rises between TIMEOUT and TIMEOUT+SYNC_STAGES+3 reference cycles after the last main-clock rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running reference clock; all control logic runs on it |
| porN | input | 1 | Power-on reset, asynchronous, active low |
| pfRst | input | 1 | Power-fail reset, synchronous, active high |
| sysRst | input | 1 | Any other system reset, synchronous, active high |
| mainClk | input | 1 | Monitored main clock |
| stopMode | input | 1 | High while software has stopped the oscillator on purpose |
| recoverLen | input | RCV_W | Reference cycles of healthy main clock needed before release |
| ctrlWe | input | 1 | Write strobe for the control field |
| ctrlWdata | input | 2 ([5:4]) | Bit 4 is the enable; bit 5 is written 0 to clear the flag |
| ctrlRdata | output | 2 ([5:4]) | Bit 4 is the enable; bit 5 is the sticky failure flag |
| failRst | output | 1 | Reset request held while a failure is active |

## Verification
The main clock is swept through half-periods whose edge spacing sits well below the timeout, up to just under it (30 cycles against 32), and then just above it and far above it (34, 48 and 80 cycles). This separates a correct threshold from one that is off by a few cycles or inverted. A fully stopped main clock is sampled at fixed points on both sides of the expected detection and release cycles, which pins down the latency and the length of the hold. The same stopped clock is then combined with stop mode, with the enable off, and with each reset type. This shows which reset clears which control bit and which ones only restart monitoring.

// File: rtl/clkfail_pkg.sv
package clkfail_pkg;

  // strobes from the control FSM to the counting datapath
  typedef struct packed {
    logic clrIdle;  // restart the no-edge window
    logic clrGood;  // restart the healthy-run count
  } guardStrobe_t;

  typedef enum logic {
    ST_WATCH = 1'b0,
    ST_FAILED = 1'b1
  } guardState_t;

  localparam int ENA_POS = 4;
  localparam int FLAG_POS = 5;

endpackage

// File: rtl/clkfail_datapath.sv
module clkfail_datapath
  import clkfail_pkg::*;
#(
  parameter int TIMEOUT = 32,
  parameter int SYNC_STAGES = 2,
  parameter int RCV_W = 8
) (
  input  logic             refClk,
  input  logic             porN,
  input  logic             mainClk,
  input  guardStrobe_t     strobe,
  output logic             expired,
  output logic [RCV_W-1:0] goodCnt
);

  localparam int IDLE_W = $clog2(TIMEOUT + 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(TIMEOUT);
  localparam logic [RCV_W-1:0] GOOD_MAX = '1;

  logic                 mainTog;
  logic [SYNC_STAGES:0] syncQ;
  logic                 edgeSeen;
  logic [IDLE_W-1:0]    idleCnt;

  // main-clock domain: one flip per rising edge
  always_ff @(posedge mainClk or negedge porN) begin
    if (!porN) mainTog <= 1'b0;
    else       mainTog <= ~mainTog;
  end

  // reference domain: synchronizer plus one history stage
  always_ff @(posedge refClk or negedge porN) begin
    if (!porN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], mainTog};
  end

  assign edgeSeen = syncQ[SYNC_STAGES] ^ syncQ[SYNC_STAGES-1];

  always_ff @(posedge refClk or negedge porN) begin
    if (!porN)                          idleCnt <= '0;
    else if (strobe.clrIdle || edgeSeen) idleCnt <= '0;
    else if (idleCnt != IDLE_MAX)       idleCnt <= idleCnt + 1'b1;
  end

  assign expired = (idleCnt == IDLE_MAX);

  always_ff @(posedge refClk or negedge porN) begin
    if (!porN)                         goodCnt <= '0;
    else if (strobe.clrGood || expired) goodCnt <= '0;
    else if (goodCnt != GOOD_MAX)      goodCnt <= goodCnt + 1'b1;
  end

endmodule

// File: rtl/clkfail_control.sv
module clkfail_control
  import clkfail_pkg::*;
#(
  parameter int RCV_W = 8
) (
  input  logic             refClk,
  input  logic             porN,
  input  logic             pfRst,
  input  logic             sysRst,
  input  logic             stopMode,
  input  logic             expired,
  input  logic [RCV_W-1:0] goodCnt,
  input  logic [RCV_W-1:0] recoverLen,
  input  logic             ctrlWe,
  input  logic [5:4]       ctrlWdata,
  output guardStrobe_t     strobe,
  output logic             failRst,
  output logic [5:4]       ctrlRdata
);

  guardState_t state;
  logic        enableBit;
  logic        flagBit;
  logic        anyRst;
  logic        enterFail;
  logic        leaveFail;

  assign anyRst    = pfRst | sysRst;
  assign enterFail = (state == ST_WATCH) && enableBit && !stopMode && expired && !anyRst;
  assign leaveFail = (state == ST_FAILED) && !expired && (goodCnt >= recoverLen);

  always_ff @(posedge refClk or negedge porN) begin
    if (!porN)          state <= ST_WATCH;
    else if (anyRst)    state <= ST_WATCH;
    else if (enterFail) state <= ST_FAILED;
    else if (leaveFail) state <= ST_WATCH;
  end

  // enable: cleared by power-on or power-fail reset, otherwise software
  always_ff @(posedge refClk or negedge porN) begin
    if (!porN)       enableBit <= 1'b0;
    else if (pfRst)  enableBit <= 1'b0;
    else if (ctrlWe) enableBit <= ctrlWdata[ENA_POS];
  end

  // flag: set by failure entry, cleared by power-on reset or a software 0
  always_ff @(posedge refClk or negedge porN) begin
    if (!porN)                                 flagBit <= 1'b0;
    else if (enterFail)                        flagBit <= 1'b1;
    else if (ctrlWe && !ctrlWdata[FLAG_POS])   flagBit <= 1'b0;
  end

  always_comb begin
    strobe.clrIdle = anyRst || ((state == ST_WATCH) && (!enableBit || stopMode));
    strobe.clrGood = anyRst || (state == ST_WATCH);
  end

  assign failRst = (state == ST_FAILED);
  assign ctrlRdata[ENA_POS]  = enableBit;
  assign ctrlRdata[FLAG_POS] = flagBit;

endmodule

// File: rtl/clkfail_guard.sv
module clkfail_guard
  import clkfail_pkg::*;
#(
  parameter int REF_HZ = 32_000_000,
  parameter int SYNC_STAGES = 2,
  parameter int RCV_W = 8
) (
  input  logic             refClk,
  input  logic             porN,
  input  logic             pfRst,
  input  logic             sysRst,
  input  logic             mainClk,
  input  logic             stopMode,
  input  logic [RCV_W-1:0] recoverLen,
  input  logic             ctrlWe,
  input  logic [5:4]       ctrlWdata,
  output logic [5:4]       ctrlRdata,
  output logic             failRst
);

  // 50 us of reference time = one period of a 20 kHz clock
  localparam int TIMEOUT = REF_HZ / 20000;

  guardStrobe_t     strobe;
  logic             expired;
  logic [RCV_W-1:0] goodCnt;

  clkfail_datapath #(
    .TIMEOUT(TIMEOUT), .SYNC_STAGES(SYNC_STAGES), .RCV_W(RCV_W)
  ) u_datapath (
    .refClk(refClk), .porN(porN), .mainClk(mainClk), .strobe(strobe),
    .expired(expired), .goodCnt(goodCnt)
  );

  clkfail_control #(.RCV_W(RCV_W)) u_control (
    .refClk(refClk), .porN(porN), .pfRst(pfRst), .sysRst(sysRst),
    .stopMode(stopMode), .expired(expired), .goodCnt(goodCnt),
    .recoverLen(recoverLen), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .strobe(strobe), .failRst(failRst), .ctrlRdata(ctrlRdata)
  );

endmodule

// File: rtl/clkfail_checker.sv
module clkfail_checker (
  input logic       refClk,
  input logic       porN,
  input logic       pfRst,
  input logic       sysRst,
  input logic       stopMode,
  input logic       ctrlWe,
  input logic [5:4] ctrlRdata,
  input logic       failRst
);

  // R4: disabled guard never raises reset
  p_no_fail_disabled_r4: assert property (@(posedge refClk) disable iff (!porN)
    (!failRst && !ctrlRdata[4]) |=> !failRst);

  // R11: stop mode suppresses detection
  p_no_fail_stop_r11: assert property (@(posedge refClk) disable iff (!porN)
    (!failRst && stopMode) |=> !failRst);

  // R8: power-fail reset clears enable and ends a failure
  p_pf_clears_r8: assert property (@(posedge refClk) disable iff (!porN)
    pfRst |=> (!ctrlRdata[4] && !failRst));

  // R9: other reset keeps both control bits
  p_sys_keeps_r9: assert property (@(posedge refClk) disable iff (!porN)
    (sysRst && !pfRst && !ctrlWe) |=> (ctrlRdata == $past(ctrlRdata)));

  // R6: flag rises only with failure entry
  p_flag_only_on_fail_r6: assert property (@(posedge refClk) disable iff (!porN)
    $rose(ctrlRdata[5]) |-> $rose(failRst));

  // R6: failure entry always sets the flag
  p_fail_sets_flag_r6: assert property (@(posedge refClk) disable iff (!porN)
    $rose(failRst) |-> ctrlRdata[5]);

endmodule

bind clkfail_guard clkfail_checker u_checker (
  .refClk(refClk), .porN(porN), .pfRst(pfRst), .sysRst(sysRst),
  .stopMode(stopMode), .ctrlWe(ctrlWe), .ctrlRdata(ctrlRdata), .failRst(failRst)
);

// File: tb/clkfail_guard_bench.sv
`timescale 1ns/1ps
module clkfail_guard_bench;

  localparam int REF_HZ = 640_000;          // TIMEOUT = 32 reference cycles
  localparam int TIMEOUT = REF_HZ / 20000;
  localparam int RCV_W = 8;

  logic refClk = 1'b0;
  logic mainClk = 1'b0;
  logic porN = 1'b0, pfRst = 1'b0, sysRst = 1'b0, stopMode = 1'b0;
  logic [RCV_W-1:0] recoverLen = 8'd40;
  logic ctrlWe = 1'b0;
  logic [5:4] ctrlWdata = 2'b00;
  logic [5:4] ctrlRdata;
  logic failRst;

  int halfNs = 8;   // 0 stops the main clock
  int tests = 0, fails = 0, cycles = 0;
  logic sawFail = 1'b0;

  clkfail_guard #(.REF_HZ(REF_HZ), .SYNC_STAGES(2), .RCV_W(RCV_W)) u_clkfail_guard (
    .refClk(refClk), .porN(porN), .pfRst(pfRst), .sysRst(sysRst),
    .mainClk(mainClk), .stopMode(stopMode), .recoverLen(recoverLen),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .ctrlRdata(ctrlRdata), .failRst(failRst)
  );

  always #2 refClk = ~refClk;   // 250 MHz

  // main clock, offset 1 ns from reference edges
  initial begin
    #1;
    forever begin
      if (halfNs == 0) #4;
      else begin
        #(halfNs);
        mainClk = ~mainClk;
      end
    end
  end

  always @(posedge refClk) begin
    #1;
    if (failRst) sawFail = 1'b1;
  end

  always @(posedge refClk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles, expected below 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge refClk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:4] d);
    ctrlWe = 1'b1; ctrlWdata = d;
    tick(1);
    ctrlWe = 1'b0;
  endtask

  initial begin
    int noFailH[5] = '{1, 2, 4, 7, 15};
    int failH[3] = '{17, 24, 40};
    tick(5);
    porN = 1'b1;
    tick(3);
    // R1 reset state
    chk(failRst == 1'b0, "R1", failRst, 0);
    chk(ctrlRdata == 2'b00, "R1", ctrlRdata, 0);

    // R4 disabled: dead clock ignored
    halfNs = 0; sawFail = 1'b0; tick(200);
    chk(!sawFail, "R4", sawFail, 0);
    halfNs = 8; tick(20);

    // R2 enable
    wr(2'b01);
    chk(ctrlRdata[4] == 1'b1, "R2", ctrlRdata[4], 1);

    // R3 edge spacing below TIMEOUT: no failure
    foreach (noFailH[i]) begin
      halfNs = noFailH[i] * 4; tick(20);
      sawFail = 1'b0; tick(300);
      chk(!sawFail, "R3", sawFail, 0);
    end

    // R3 edge spacing above TIMEOUT: failure, flag, recovery, clear
    foreach (failH[i]) begin
      halfNs = failH[i] * 4; tick(400);
      chk(failRst == 1'b1, "R3", failRst, 1);
      chk(ctrlRdata[5] == 1'b1, "R6", ctrlRdata[5], 1);
      halfNs = 8; tick(100);
      chk(failRst == 1'b0, "R5", failRst, 0);
      wr(2'b01);
      chk(ctrlRdata == 2'b01, "R7", ctrlRdata, 1);
    end

    // R12 latency and R5 hold length
    recoverLen = 8'd20;
    tick(20);
    halfNs = 0; tick(28);
    chk(failRst == 1'b0, "R12", failRst, 0);
    tick(14);
    chk(failRst == 1'b1, "R12", failRst, 1);
    tick(50);
    halfNs = 8; tick(14);
    chk(failRst == 1'b1, "R5", failRst, 1);
    tick(26);
    chk(failRst == 1'b0, "R5", failRst, 0);

    // R7 writing 1 to flag does not set it
    wr(2'b01);
    wr(2'b11);
    chk(ctrlRdata == 2'b01, "R7", ctrlRdata, 1);

    // R11 stop mode suppresses, then full window restarts
    stopMode = 1'b1; halfNs = 0; sawFail = 1'b0; tick(200);
    chk(!sawFail, "R11", sawFail, 0);
    stopMode = 1'b0; sawFail = 1'b0; tick(28);
    chk(!sawFail, "R11", sawFail, 0);
    tick(14);
    chk(failRst == 1'b1, "R11", failRst, 1);

    // R9 other reset: bits kept, failure dropped, monitoring resumes
    sysRst = 1'b1; tick(1); sysRst = 1'b0;
    chk(failRst == 1'b0, "R9", failRst, 0);
    chk(ctrlRdata == 2'b11, "R9", ctrlRdata, 3);
    tick(40);
    chk(failRst == 1'b1, "R9", failRst, 1);

    // R8 power-fail reset: enable cleared, flag kept, failure ended
    pfRst = 1'b1; tick(1); pfRst = 1'b0;
    chk(failRst == 1'b0, "R8", failRst, 0);
    chk(ctrlRdata == 2'b10, "R8", ctrlRdata, 2);
    sawFail = 1'b0; tick(100);
    chk(!sawFail, "R8", sawFail, 0);

    // R10 power-on reset clears flag too
    porN = 1'b0; tick(2); porN = 1'b1; tick(2);
    chk(ctrlRdata == 2'b00, "R10", ctrlRdata, 0);
    chk(failRst == 1'b0, "R10", failRst, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule